// File: doc/BRIEF.md
# Chip-Wide Clock Level Voter

This block sets one operating level for the core clock and one for the memory clock for the whole chip. Each epoch, every core sends a preference for each of the two clock domains: lower the clock, keep it, or raise it. The block holds each core's preference until all cores have reported. It then takes a separate majority vote for each domain and moves that domain's level register by at most one step. The level cannot go below the lowest level or above the highest.

Votes come in over a valid/ready handshake, one per core. A core's vote is taken on a clock edge where its `vote_valid` and `vote_ready` are both high. After that, the core's `vote_ready` stays low until the epoch resolves, so the core must hold its next vote. Changes on `vote_valid` or on the vote buses while `vote_ready` is low have no effect. The block holds no other buffering. The outputs are the two level registers and a one-cycle update strobe.

Top module: `freq_vote_top`

## Requirements
- R1: During and after reset, and before any epoch resolves, `core_level` and `mem_level` both equal the nominal level 2, `level_update` is 0 and every `vote_ready` bit is 1.
- R2: A core's vote is taken on a clock edge where its `vote_valid` and `vote_ready` are both 1. Its `vote_ready` is then 0 from that edge until the epoch resolves. While it is 0, any change on that core's `vote_valid` or vote fields has no effect on the result.
- R3: Let E be the edge that accepts the last outstanding vote. The levels do not change before edge E+1. At edge E+1 they take their new values and every `vote_ready` returns to 1.
- R4: Each vote uses a 2-bit field per core, with core i at bits [2i+1:2i]. Code 01 means up. If strictly more than half of the cores vote up for a domain, that domain's level rises by one.
- R5: Code 10 means down. If strictly more than half of the cores vote down for a domain, that domain's level falls by one.
- R6: Code 00 means hold, and the spare code 11 is also counted as hold. If neither up nor down has a strict majority, the level is unchanged.
- R7: Levels range from 0 to 3. A winning up vote at level 3 leaves the level at 3. A winning down vote at level 0 leaves it at 0.
- R8: The core-clock level depends only on the `core_vote` fields. The memory-clock level depends only on the `mem_vote` fields.
- R9: `level_update` is 1 for exactly the one cycle after edge E+1 when at least one level changed at that edge. It is 0 at all other times.
- R10: A level never changes by more than one step at a single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vote_valid | input | NUM_CORES | One bit per core: that core's vote fields are valid |
| vote_ready | output | NUM_CORES | One bit per core: the block can take that core's vote |
| core_vote | input | 2*NUM_CORES | Core-clock vote fields, 2 bits per core |
| mem_vote | input | 2*NUM_CORES | Memory-clock vote fields, 2 bits per core |
| core_level | output | LVL_W | Current chip-wide core-clock level |
| mem_level | output | LVL_W | Current chip-wide memory-clock level |
| level_update | output | 1 | One-cycle strobe when a level changed |

## Verification
The assertions assume each core sends at most one vote per epoch. A core does this by never raising a second vote while its ready is low. Because of that, an epoch always lasts at least two cycles, and two update strobes cannot land on adjacent cycles.

The stimulus offers one core per cycle, in a rotating order, so every epoch respects this. It also keeps every already-accepted core's valid raised with inverted vote codes, which shows that those inputs are ignored. It drops all valids before the cycle after the epoch resolves, so no stale vote is taken into the next epoch.

// File: rtl/fvote_pkg.sv
package fvote_pkg;
  typedef enum logic [1:0] {
    VOTE_HOLD = 2'b00,
    VOTE_UP   = 2'b01,
    VOTE_DOWN = 2'b10,
    VOTE_SPARE = 2'b11
  } vote_e;

  typedef enum logic [1:0] {
    STEP_KEEP = 2'b00,
    STEP_RAISE = 2'b01,
    STEP_LOWER = 2'b10
  } step_e;
endpackage

// File: rtl/vote_collector.sv
module vote_collector #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   vote_valid,
  input  logic [2*N-1:0] core_vote,
  input  logic [2*N-1:0] mem_vote,
  input  logic           clear,
  output logic [N-1:0]   vote_ready,
  output logic [2*N-1:0] core_held,
  output logic [2*N-1:0] mem_held,
  output logic           all_in
);
  logic [N-1:0] have;

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        have[i]           <= 1'b0;
        core_held[2*i +: 2] <= 2'b00;
        mem_held[2*i +: 2]  <= 2'b00;
      end else if (clear) begin
        have[i] <= 1'b0;
      end else if (vote_valid[i] && !have[i]) begin
        have[i]             <= 1'b1;
        core_held[2*i +: 2] <= core_vote[2*i +: 2];
        mem_held[2*i +: 2]  <= mem_vote[2*i +: 2];
      end
    end
  end

  assign vote_ready = ~have;
  assign all_in     = &have;
endmodule

// File: rtl/majority_tally.sv
module majority_tally
  import fvote_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [2*N-1:0] votes,
  output step_e          step
);
  localparam int CW = $clog2(N + 1) + 1;

  logic [CW-1:0] n_up, n_down;

  always_comb begin
    n_up   = '0;
    n_down = '0;
    for (int i = 0; i < N; i++) begin
      if (vote_e'(votes[2*i +: 2]) == VOTE_UP)   n_up   = n_up + 1'b1;
      if (vote_e'(votes[2*i +: 2]) == VOTE_DOWN) n_down = n_down + 1'b1;
    end
    if ({n_up, 1'b0} > (CW + 1)'(N))        step = STEP_RAISE;
    else if ({n_down, 1'b0} > (CW + 1)'(N)) step = STEP_LOWER;
    else                                    step = STEP_KEEP;
  end
endmodule

// File: rtl/level_stepper.sv
module level_stepper
  import fvote_pkg::*;
#(
  parameter int LVL_W   = 2,
  parameter int MAX_LVL = 3,
  parameter int RST_LVL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  step_e            step,
  output logic [LVL_W-1:0] level,
  output logic             will_change
);
  localparam logic [LVL_W-1:0] TOP  = LVL_W'(MAX_LVL);
  localparam logic [LVL_W-1:0] INIT = LVL_W'(RST_LVL);

  logic [LVL_W-1:0] next_lvl;

  always_comb begin
    next_lvl = level;
    unique case (step)
      STEP_RAISE: if (level != TOP)  next_lvl = level + 1'b1;
      STEP_LOWER: if (level != '0)   next_lvl = level - 1'b1;
      default:    next_lvl = level;
    endcase
  end

  assign will_change = apply && (next_lvl != level);

  always_ff @(posedge clk) begin
    if (!rst_n)     level <= INIT;
    else if (apply) level <= next_lvl;
  end
endmodule

// File: rtl/freq_vote_top.sv
module freq_vote_top
  import fvote_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int NUM_LEVELS  = 4,
  parameter int RESET_LEVEL = 2,
  parameter int LVL_W       = $clog2(NUM_LEVELS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CORES-1:0]   vote_valid,
  output logic [NUM_CORES-1:0]   vote_ready,
  input  logic [2*NUM_CORES-1:0] core_vote,
  input  logic [2*NUM_CORES-1:0] mem_vote,
  output logic [LVL_W-1:0]       core_level,
  output logic [LVL_W-1:0]       mem_level,
  output logic                   level_update
);
  localparam int MAX_LVL = NUM_LEVELS - 1;

  logic [2*NUM_CORES-1:0] core_held, mem_held;
  logic  all_in;
  step_e core_step, mem_step;
  logic  core_chg, mem_chg;

  vote_collector #(.N(NUM_CORES)) u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .vote_valid (vote_valid),
    .core_vote  (core_vote),
    .mem_vote   (mem_vote),
    .clear      (all_in),
    .vote_ready (vote_ready),
    .core_held  (core_held),
    .mem_held   (mem_held),
    .all_in     (all_in)
  );

  majority_tally #(.N(NUM_CORES)) u_tally_core (.votes(core_held), .step(core_step));
  majority_tally #(.N(NUM_CORES)) u_tally_mem  (.votes(mem_held),  .step(mem_step));

  level_stepper #(.LVL_W(LVL_W), .MAX_LVL(MAX_LVL), .RST_LVL(RESET_LEVEL)) u_step_core (
    .clk (clk), .rst_n (rst_n), .apply (all_in), .step (core_step),
    .level (core_level), .will_change (core_chg)
  );

  level_stepper #(.LVL_W(LVL_W), .MAX_LVL(MAX_LVL), .RST_LVL(RESET_LEVEL)) u_step_mem (
    .clk (clk), .rst_n (rst_n), .apply (all_in), .step (mem_step),
    .level (mem_level), .will_change (mem_chg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) level_update <= 1'b0;
    else        level_update <= core_chg | mem_chg;
  end
endmodule

// File: rtl/fvote_checker.sv
module fvote_checker #(
  parameter int N       = 4,
  parameter int LVL_W   = 2,
  parameter int MAX_LVL = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     vote_valid,
  input logic [N-1:0]     vote_ready,
  input logic [LVL_W-1:0] core_level,
  input logic [LVL_W-1:0] mem_level,
  input logic             level_update
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(MAX_LVL);

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_level <= TOP) && (mem_level <= TOP));

  assert_core_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_level != $past(core_level)) |->
      (core_level == $past(core_level) + 1'b1 || core_level == $past(core_level) - 1'b1));

  assert_mem_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_level != $past(mem_level)) |->
      (mem_level == $past(mem_level) + 1'b1 || mem_level == $past(mem_level) - 1'b1));

  assert_strobe_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_level != $past(core_level) || mem_level != $past(mem_level)) |-> level_update);

  assert_strobe_needs_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    level_update |-> (core_level != $past(core_level) || mem_level != $past(mem_level)));

  assert_strobe_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    level_update |=> !level_update);

  assert_change_after_all_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level_update |-> ($past(vote_ready) == '0 && vote_ready == '1));

  for (genvar i = 0; i < N; i++) begin : g_rdy
    assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (vote_valid[i] && vote_ready[i]) |=> !vote_ready[i]);
  end
endmodule

bind freq_vote_top fvote_checker #(
  .N(NUM_CORES), .LVL_W(LVL_W), .MAX_LVL(NUM_LEVELS - 1)
) u_fvote_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .vote_valid   (vote_valid),
  .vote_ready   (vote_ready),
  .core_level   (core_level),
  .mem_level    (mem_level),
  .level_update (level_update)
);

// File: tb/tb_freq_vote_top.sv
module tb_freq_vote_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  vote_valid = '0;
  logic [N-1:0]  vote_ready;
  logic [2*N-1:0] core_vote = '0;
  logic [2*N-1:0] mem_vote = '0;
  logic [LW-1:0] core_level, mem_level;
  logic          level_update;

  int checks = 0;
  int errors = 0;
  int exp_core = 2;
  int exp_mem = 2;

  always #(CLK_PERIOD / 2) clk = ~clk;

  freq_vote_top #(.NUM_CORES(N), .NUM_LEVELS(4), .RESET_LEVEL(2)) dut (
    .clk (clk), .rst_n (rst_n), .vote_valid (vote_valid), .vote_ready (vote_ready),
    .core_vote (core_vote), .mem_vote (mem_vote), .core_level (core_level),
    .mem_level (mem_level), .level_update (level_update)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_step(input int lv, input logic [2*N-1:0] pat, output string tag);
    int ups = 0;
    int downs = 0;
    for (int i = 0; i < N; i++) begin
      if (pat[2*i +: 2] == 2'b01) ups++;
      if (pat[2*i +: 2] == 2'b10) downs++;
    end
    if (2 * ups > N) begin
      if (lv == 3) begin tag = "R7"; return lv; end
      tag = "R4"; return lv + 1;
    end
    if (2 * downs > N) begin
      if (lv == 0) begin tag = "R7"; return lv; end
      tag = "R5"; return lv - 1;
    end
    tag = "R6";
    return lv;
  endfunction

  task automatic run_epoch(input logic [2*N-1:0] cp, input logic [2*N-1:0] mp, input int e);
    logic [N-1:0] acc = '0;
    int nc, nm, oc, om;
    string tc, tm;
    @(negedge clk);
    check("R9 idle strobe", level_update, 0);
    check("R2 ready idle", vote_ready, (1 << N) - 1);
    for (int k = 0; k < N; k++) begin
      int j = (k + e) % N;
      if (k > 0) @(negedge clk);
      if (k > 0) check("R3 early hold core", core_level, exp_core);
      for (int q = 0; q < N; q++) begin
        core_vote[2*q +: 2] = (q == j) ? cp[2*q +: 2] : ~cp[2*q +: 2];
        mem_vote[2*q +: 2]  = (q == j) ? mp[2*q +: 2] : ~mp[2*q +: 2];
      end
      vote_valid = acc | (N'(1) << j);
      acc = vote_valid;
    end
    @(negedge clk);
    check("R2 ready low after accept", vote_ready, 0);
    check("R3 no change before resolve core", core_level, exp_core);
    check("R3 no change before resolve mem", mem_level, exp_mem);
    core_vote = ~cp;
    mem_vote = ~mp;
    @(negedge clk);
    vote_valid = '0;
    oc = exp_core; om = exp_mem;
    nc = model_step(exp_core, cp, tc);
    nm = model_step(exp_mem, mp, tm);
    exp_core = nc; exp_mem = nm;
    check({tc, " core level"}, core_level, nc);
    check({tm, " mem level"}, mem_level, nm);
    if (tc != tm) check("R8 domains independent", mem_level * 4 + core_level, nm * 4 + nc);
    check("R9 strobe on change", level_update, (nc != oc || nm != om) ? 1 : 0);
    check("R10 single step", (core_level > oc ? core_level - oc : oc - core_level) <= 1, 1);
    check("R3 ready restored", vote_ready, (1 << N) - 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset core level", core_level, 2);
    check("R1 reset mem level", mem_level, 2);
    check("R1 reset strobe", level_update, 0);
    check("R1 reset ready", vote_ready, (1 << N) - 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset core level", core_level, 2);
    // drive core up to saturation, memory down to saturation
    for (int e = 0; e < 4; e++) run_epoch(8'b01_01_01_01, 8'b10_10_10_10, e);
    // reverse direction, crossing full range
    for (int e = 0; e < 5; e++) run_epoch(8'b10_10_10_00, 8'b01_11_01_01, e);
    // split votes: no strict majority
    run_epoch(8'b01_01_10_10, 8'b01_01_00_11, 1);
    // exhaustive core pattern sweep, scrambled memory pattern
    for (int e = 0; e < 256; e++) run_epoch(8'(e), 8'((e * 37 + 11) % 256), e);
    @(negedge clk);
    check("R9 strobe quiet at end", level_update, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule